// File: doc/BRIEF.md
# Memory Map Decoder with Boot Overlay

This block turns a 24-bit CPU address and its address strobe into one-hot chip enables for eight regions: vector RAM, low SRAM, internal IO, main RAM, the expansion window, frame-buffer shadow RAM, the frame buffer and flash. The decode is purely combinational from the address, so an enable is valid in the same cycle as the strobe. The only state is a single overlay flag.

After reset, the bottom 256 bytes (the vector area) are served by flash. A write to one fixed internal IO address sets a sticky flag. From the next cycle on, the vector area is served by its own RAM. Only reset clears the flag.

The expansion window holds eight fixed 16 KiB card slots followed by an open area for cards on the dynamic bus. For each access the block produces:
- a one-hot slot select, or a dynamic-bus select;
- an enable for the slot address and data buffers, which isolates the cards whenever none is addressed;
- the 14-bit offset inside the card;
- a two-bit timing class.

Top module: `mmap_decoder`

## Requirements
- R1: While `as_valid_i` is high and the address lies in a mapped window, exactly one bit of `en_o` is high. The bit positions are: 0 vector RAM, 1 SRAM, 2 internal IO, 3 main RAM, 4 expansion, 5 frame-buffer shadow, 6 frame buffer, 7 flash.
- R2: The windows are inclusive: vector 0x000000–0x0000FF, SRAM 0x000100–0x017FFF, IO 0x018000–0x01FFFF, main RAM 0x020000–0x81FFFF, expansion 0x820000–0x9DFFFF, shadow 0xA00000–0xBFFFFF, frame buffer 0xC00000–0xDFFFFF, flash 0xE00000–0xFFFFFF.
- R3: Until the overlay flag is set, a strobed access to the vector window asserts `en_o[7]` (flash) and not `en_o[0]`.
- R4: A strobed write (`wr_i`=1) to 0x018040 sets the overlay flag at that clock edge. From the next cycle, vector-window accesses assert `en_o[0]`. Reads of that address, and writes to other IO addresses, leave the flag clear.
- R5: Once set, the flag stays set through further accesses. Only a synchronous low `rst_n` clears it.
- R6: A strobed access to the unmapped gap 0x9E0000–0x9FFFFF raises `bus_err_o` and asserts no enable.
- R7: For 0x820000–0x83FFFF, `slot_sel_o` has exactly one bit high, namely bit `addr[16:14]`, and `dyn_sel_o` is low.
- R8: For 0x840000–0x9DFFFF, `dyn_sel_o` is high and `slot_sel_o` is zero.
- R9: `buf_en_o` is high exactly when a slot or dynamic-bus card is selected.
- R10: `card_off_o` equals `addr[13:0]` while a card is selected and is zero otherwise.
- R11: `timing_o` is 00 (7.5 MHz slot timing) for slot accesses. For dynamic-bus accesses it follows `cap_i`: 00 gives 01 (legacy bus timing), 01 gives 10 (16 MHz), and 1x gives 11 (CPU-native). Every other access reports 11.
- R12: With `as_valid_i` low, `en_o`, `slot_sel_o`, `dyn_sel_o`, `buf_en_o`, `bus_err_o` and `card_off_o` are all zero, `timing_o` is 11, and the flag cannot change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears the overlay flag |
| as_valid_i | input | 1 | Address strobe: the address is valid this cycle |
| wr_i | input | 1 | Access is a write |
| addr_i | input | 24 | CPU byte address |
| cap_i | input | 2 | Capability bits of the addressed dynamic-bus card |
| en_o | output | 8 | One-hot region chip enables |
| bus_err_o | output | 1 | Strobed access hit no window |
| slot_sel_o | output | 8 | One-hot select of a fixed 16 KiB card slot |
| dyn_sel_o | output | 1 | Select for the dynamic-bus card area |
| buf_en_o | output | 1 | Enable for the slot address and data buffers |
| card_off_o | output | 14 | Offset inside the addressed card |
| timing_o | output | 2 | Timing class of the access |

## Verification
The first and last byte of every window and of the gap are applied twice: once before the overlay write and once after it. An off-by-one at any limit therefore shows up as the wrong enable or a spurious bus error, and the vector window shows whether the flag steers it to flash or to RAM. A read of the trigger address and a write to a neighbouring IO register separate a correct trigger match from a loose one. A second trigger write and a mid-run reset separate a sticky flag from a toggling one. Every slot is addressed at an interior offset, which separates slot index bits from offset bits, and all four capability codes are applied in the dynamic area to tell the timing classes apart. Idle cycles with arbitrary addresses show that no output leaks without a strobe.

// File: rtl/mmap_pkg.sv
// Package: shared region indices and timing-class codes of the memory map decoder.
// Assumes: eight regions whose enable bit positions are fixed by the enum values below.
package mmap_pkg;

    localparam int NUM_REGIONS = 8;

    // Enable bit positions; neighbouring logic decodes these.
    typedef enum logic [2:0] {
        RG_VEC_RAM = 3'd0,
        RG_SRAM    = 3'd1,
        RG_IO      = 3'd2,
        RG_RAM     = 3'd3,
        RG_EXP     = 3'd4,
        RG_FBSH    = 3'd5,
        RG_FB      = 3'd6,
        RG_FLASH   = 3'd7
    } region_e;

    typedef enum logic [1:0] {
        TM_SLOT   = 2'b00,
        TM_LEGACY = 2'b01,
        TM_16M    = 2'b10,
        TM_NATIVE = 2'b11
    } timing_e;

    // Map card capability bits to a dynamic-bus timing class.
    function automatic timing_e cap_to_timing(input logic [1:0] cap);
        case (cap)
            2'b00:   return TM_LEGACY;
            2'b01:   return TM_16M;
            default: return TM_NATIVE;
        endcase
    endfunction

endpackage

// File: rtl/mmap_window_match.sv
// Module: parallel inclusive range compare of an address against NUM_WIN windows.
// Assumes: windows are disjoint, so at most one hit bit is high; the limits are constants.
module mmap_window_match #(
    parameter int ADDR_W  = 24,
    parameter int NUM_WIN = 8,
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_LO = '0,
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_HI = '1
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_WIN-1:0] hit
);

    localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

    // One comparator pair per window; a limit that is an address-space edge is dropped.
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        if (WIN_LO[i] == '0 && WIN_HI[i] == ADDR_MAX) begin : g_all
            assign hit[i] = 1'b1;
        end else if (WIN_LO[i] == '0) begin : g_low
            assign hit[i] = (addr <= WIN_HI[i]);
        end else if (WIN_HI[i] == ADDR_MAX) begin : g_high
            assign hit[i] = (addr >= WIN_LO[i]);
        end else begin : g_mid
            assign hit[i] = (addr >= WIN_LO[i]) && (addr <= WIN_HI[i]);
        end
    end

endmodule

// File: rtl/mmap_boot_overlay.sv
// Module: sticky flag that moves the vector area from flash to RAM.
// Assumes: set_i is a single-cycle qualified trigger; only the synchronous reset clears the flag.
module mmap_boot_overlay (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    output logic swapped_o
);

    // Hold the flag once set; only reset returns the vector area to flash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swapped_o <= 1'b0;
        end else if (set_i) begin
            swapped_o <= 1'b1;
        end
    end

endmodule

// File: rtl/mmap_exp_select.sv
// Module: card selects, card offset and timing class inside the expansion window.
// Assumes: exp_hit is high only for addresses inside the expansion window.
// The fixed slots sit at the window base; the rest belongs to the dynamic bus.
module mmap_exp_select
    import mmap_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int SLOT_COUNT = 8,
    parameter int SLOT_AW    = 14,
    parameter logic [ADDR_W-1:0] EXP_BASE = 24'h820000
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  exp_hit,
    input  logic [1:0]            cap,
    output logic [SLOT_COUNT-1:0] slot_sel,
    output logic                  dyn_sel,
    output logic [SLOT_AW-1:0]    card_off,
    output timing_e               timing
);

    localparam int IDX_W = (SLOT_COUNT > 1) ? $clog2(SLOT_COUNT) : 1;
    localparam logic [ADDR_W-1:0] SLOT_SPAN = ADDR_W'(SLOT_COUNT * (2 ** SLOT_AW));

    logic [ADDR_W-1:0] rel;
    logic              in_slots;
    logic [IDX_W-1:0]  idx;

    // Position relative to the window base, and which slot it falls in.
    always_comb begin
        rel      = addr - EXP_BASE;
        in_slots = exp_hit && (rel < SLOT_SPAN);
        idx      = rel[SLOT_AW +: IDX_W];
    end

    // One select line per fixed slot.
    for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
        assign slot_sel[s] = in_slots && (idx == IDX_W'(s));
    end

    // Dynamic-bus select, card offset and timing class.
    always_comb begin
        dyn_sel  = exp_hit && !in_slots;
        card_off = exp_hit ? addr[SLOT_AW-1:0] : '0;
        if (in_slots) begin
            timing = TM_SLOT;
        end else if (dyn_sel) begin
            timing = cap_to_timing(cap);
        end else begin
            timing = TM_NATIVE;
        end
    end

endmodule

// File: rtl/mmap_decoder.sv
// Module: top of the memory map decoder with boot overlay.
// Decodes a strobed address into one-hot region enables, expansion card selects, a buffer
// enable, a card offset and a timing class. It also flags unmapped accesses.
// Assumes: the address and strobe are stable for the cycle; the outputs are combinational.
module mmap_decoder
    import mmap_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int SLOT_COUNT = 8,
    parameter int SLOT_AW    = 14,
    parameter logic [ADDR_W-1:0] VEC_BASE   = 24'h000000,
    parameter logic [ADDR_W-1:0] VEC_TOP    = 24'h0000FF,
    parameter logic [ADDR_W-1:0] SRAM_TOP   = 24'h017FFF,
    parameter logic [ADDR_W-1:0] IO_TOP     = 24'h01FFFF,
    parameter logic [ADDR_W-1:0] RAM_TOP    = 24'h81FFFF,
    parameter logic [ADDR_W-1:0] EXP_TOP    = 24'h9DFFFF,
    parameter logic [ADDR_W-1:0] FBSH_BASE  = 24'hA00000,
    parameter logic [ADDR_W-1:0] FBSH_TOP   = 24'hBFFFFF,
    parameter logic [ADDR_W-1:0] FB_TOP     = 24'hDFFFFF,
    parameter logic [ADDR_W-1:0] FLASH_TOP  = 24'hFFFFFF,
    parameter logic [ADDR_W-1:0] SWAP_ADDR  = 24'h018040
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  as_valid_i,
    input  logic                  wr_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [1:0]            cap_i,
    output logic [NUM_REGIONS-1:0] en_o,
    output logic                  bus_err_o,
    output logic [SLOT_COUNT-1:0] slot_sel_o,
    output logic                  dyn_sel_o,
    output logic                  buf_en_o,
    output logic [SLOT_AW-1:0]    card_off_o,
    output logic [1:0]            timing_o
);

    // Window bases are derived from the top of the window below, except where a gap exists.
    localparam logic [ADDR_W-1:0] SRAM_BASE  = VEC_TOP + 1'b1;
    localparam logic [ADDR_W-1:0] IO_BASE    = SRAM_TOP + 1'b1;
    localparam logic [ADDR_W-1:0] RAM_BASE   = IO_TOP + 1'b1;
    localparam logic [ADDR_W-1:0] EXP_BASE   = RAM_TOP + 1'b1;
    localparam logic [ADDR_W-1:0] FB_BASE    = FBSH_TOP + 1'b1;
    localparam logic [ADDR_W-1:0] FLASH_BASE = FB_TOP + 1'b1;

    // Index i of each table is the window behind enable bit i.
    localparam logic [NUM_REGIONS-1:0][ADDR_W-1:0] WIN_LO =
        {FLASH_BASE, FB_BASE, FBSH_BASE, EXP_BASE, RAM_BASE, IO_BASE, SRAM_BASE, VEC_BASE};
    localparam logic [NUM_REGIONS-1:0][ADDR_W-1:0] WIN_HI =
        {FLASH_TOP, FB_TOP, FBSH_TOP, EXP_TOP, RAM_TOP, IO_TOP, SRAM_TOP, VEC_TOP};

    logic [NUM_REGIONS-1:0] win_hit;
    logic [NUM_REGIONS-1:0] en_map;
    logic                   swap_set;
    logic                   swap_done;
    logic [SLOT_COUNT-1:0]  exp_slot;
    logic                   exp_dyn;
    logic [SLOT_AW-1:0]     exp_off;
    timing_e                exp_timing;

    mmap_window_match #(
        .ADDR_W  (ADDR_W),
        .NUM_WIN (NUM_REGIONS),
        .WIN_LO  (WIN_LO),
        .WIN_HI  (WIN_HI)
    ) u_match (
        .addr (addr_i),
        .hit  (win_hit)
    );

    // Trigger: a strobed write to the one overlay register inside internal IO.
    assign swap_set = as_valid_i && wr_i && (addr_i == SWAP_ADDR);

    mmap_boot_overlay u_overlay (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (swap_set),
        .swapped_o (swap_done)
    );

    mmap_exp_select #(
        .ADDR_W     (ADDR_W),
        .SLOT_COUNT (SLOT_COUNT),
        .SLOT_AW    (SLOT_AW),
        .EXP_BASE   (EXP_BASE)
    ) u_exp (
        .addr     (addr_i),
        .exp_hit  (win_hit[RG_EXP]),
        .cap      (cap_i),
        .slot_sel (exp_slot),
        .dyn_sel  (exp_dyn),
        .card_off (exp_off),
        .timing   (exp_timing)
    );

    // Before the swap, fold the vector window onto the flash enable.
    always_comb begin
        en_map = win_hit;
        if (!swap_done) begin
            en_map[RG_VEC_RAM] = 1'b0;
            en_map[RG_FLASH]   = win_hit[RG_FLASH] | win_hit[RG_VEC_RAM];
        end
    end

    // Qualify every output with the address strobe.
    always_comb begin
        en_o       = as_valid_i ? en_map : '0;
        bus_err_o  = as_valid_i && (win_hit == '0);
        slot_sel_o = as_valid_i ? exp_slot : '0;
        dyn_sel_o  = as_valid_i && exp_dyn;
        buf_en_o   = as_valid_i && ((exp_slot != '0) || exp_dyn);
        card_off_o = as_valid_i ? exp_off : '0;
        timing_o   = as_valid_i ? exp_timing : TM_NATIVE;
    end

endmodule

// File: rtl/mmap_decoder_checker.sv
// Module: temporal checks on the memory map decoder, attached by bind.
// Assumes: it sees the ports of the top and the overlay flag from the flag register.
module mmap_decoder_checker #(
    parameter int ADDR_W     = 24,
    parameter int SLOT_COUNT = 8,
    parameter int SLOT_AW    = 14,
    parameter logic [ADDR_W-1:0] VEC_TOP   = 24'h0000FF,
    parameter logic [ADDR_W-1:0] SWAP_ADDR = 24'h018040
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  as_valid_i,
    input logic                  wr_i,
    input logic [ADDR_W-1:0]     addr_i,
    input logic [7:0]            en_o,
    input logic                  bus_err_o,
    input logic [SLOT_COUNT-1:0] slot_sel_o,
    input logic                  dyn_sel_o,
    input logic                  buf_en_o,
    input logic [SLOT_AW-1:0]    card_off_o,
    input logic                  swapped
);

    // A strobed access either selects exactly one region or reports a bus error.
    p_one_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (as_valid_i && !bus_err_o) |-> ($countones(en_o) == 1));

    // Before the swap, the vector window is served by flash.
    p_vec_flash_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (as_valid_i && !swapped && addr_i <= VEC_TOP) |-> (en_o[7] && !en_o[0]));

    // A trigger write sets the overlay flag at the next edge.
    p_swap_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (as_valid_i && wr_i && addr_i == SWAP_ADDR) |=> swapped);

    // The flag never falls outside reset.
    p_swap_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        swapped |=> swapped);

    // An unmapped access asserts no enable.
    p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_o |-> (en_o == '0));

    // At most one slot select, never together with the dynamic select.
    p_slot_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(slot_sel_o) <= 1) && !(dyn_sel_o && slot_sel_o != '0));

    // The card buffers open only for an expansion access with a card selected.
    p_buf_exp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_en_o |-> (en_o[4] && (dyn_sel_o || slot_sel_o != '0)));

    // The card offset is zero while the buffers are closed.
    p_off_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_en_o |-> (card_off_o == '0));

    // With no strobe, every select is low and the flag holds.
    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !as_valid_i |-> (en_o == '0 && !bus_err_o && !buf_en_o && slot_sel_o == '0)
                        ##1 $stable(swapped));

endmodule

bind mmap_decoder mmap_decoder_checker #(
    .ADDR_W     (ADDR_W),
    .SLOT_COUNT (SLOT_COUNT),
    .SLOT_AW    (SLOT_AW),
    .VEC_TOP    (VEC_TOP),
    .SWAP_ADDR  (SWAP_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .as_valid_i (as_valid_i),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .en_o       (en_o),
    .bus_err_o  (bus_err_o),
    .slot_sel_o (slot_sel_o),
    .dyn_sel_o  (dyn_sel_o),
    .buf_en_o   (buf_en_o),
    .card_off_o (card_off_o),
    .swapped    (swap_done)
);

// File: tb/mmap_decoder_bench.sv
// Bench: behavioural reference model of the memory map, compared on every applied cycle.
module mmap_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_valid_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [23:0] addr_i = '0;
    logic [1:0]  cap_i = '0;
    logic [7:0]  en_o;
    logic        bus_err_o;
    logic [7:0]  slot_sel_o;
    logic        dyn_sel_o;
    logic        buf_en_o;
    logic [13:0] card_off_o;
    logic [1:0]  timing_o;

    int vectors = 0;
    int fails = 0;
    bit m_swapped = 1'b0;

    always #5 clk = ~clk;

    mmap_decoder u_mmap_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .as_valid_i (as_valid_i),
        .wr_i       (wr_i),
        .addr_i     (addr_i),
        .cap_i      (cap_i),
        .en_o       (en_o),
        .bus_err_o  (bus_err_o),
        .slot_sel_o (slot_sel_o),
        .dyn_sel_o  (dyn_sel_o),
        .buf_en_o   (buf_en_o),
        .card_off_o (card_off_o),
        .timing_o   (timing_o)
    );

    // Reference model: expected outputs packed as {en, err, slot, dyn, buf, off, timing}.
    function automatic logic [35:0] model(input bit v, input int a, input int c, input bit sw);
        logic [7:0] en = '0, slot = '0;
        logic err = 0, dyn = 0, bufe = 0;
        logic [13:0] off = '0;
        logic [1:0] tim = 2'b11;
        if (v) begin
            if (a < 'h100)           en[sw ? 0 : 7] = 1'b1;
            else if (a < 'h18000)    en[1] = 1'b1;
            else if (a < 'h20000)    en[2] = 1'b1;
            else if (a < 'h820000)   en[3] = 1'b1;
            else if (a < 'h9E0000) begin
                en[4] = 1'b1;
                bufe = 1'b1;
                off = 14'(a % 16384);
                if (a < 'h840000) begin
                    slot[(a - 'h820000) / 16384] = 1'b1;
                    tim = 2'b00;
                end else begin
                    dyn = 1'b1;
                    tim = (c == 0) ? 2'b01 : (c == 1) ? 2'b10 : 2'b11;
                end
            end
            else if (a < 'hA00000)   err = 1'b1;
            else if (a < 'hC00000)   en[5] = 1'b1;
            else if (a < 'hE00000)   en[6] = 1'b1;
            else                     en[7] = 1'b1;
        end
        return {en, err, slot, dyn, bufe, off, tim};
    endfunction

    // Drive one cycle, compare before the next edge, then advance the model flag.
    task automatic apply(input bit rst, input bit v, input bit w, input int a, input int c,
                         input string tag);
        logic [35:0] exp_v, act_v;
        @(negedge clk);
        rst_n = ~rst; as_valid_i = v; wr_i = w; addr_i = 24'(a); cap_i = 2'(c);
        #4;
        exp_v = model(v, a, c, m_swapped);
        act_v = {en_o, bus_err_o, slot_sel_o, dyn_sel_o, buf_en_o, card_off_o, timing_o};
        vectors++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s addr=%06h actual=%09h expected=%09h", tag, a, act_v, exp_v);
        end
        if (rst) m_swapped = 1'b0;
        else if (v && w && a == 'h018040) m_swapped = 1'b1;
        @(posedge clk);
    endtask

    // Boundary addresses of every window and of the gap (R2, R6).
    task automatic sweep(input string tag);
        int bounds[22] = '{'h000000, 'h0000FF, 'h000100, 'h017FFF, 'h018000, 'h01FFFF,
                           'h020000, 'h81FFFF, 'h820000, 'h823FFF, 'h824000, 'h83FFFF,
                           'h840000, 'h9DFFFF, 'h9E0000, 'h9FFFFF, 'hA00000, 'hBFFFFF,
                           'hC00000, 'hDFFFFF, 'hE00000, 'hFFFFFF};
        foreach (bounds[i]) apply(0, 1, i % 2, bounds[i], i % 4, tag);
    endtask

    initial begin : watchdog
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : stim
        logic [23:0] lfsr = 24'hACE123;
        apply(1, 0, 0, 0, 0, "R12");            // reset state
        apply(1, 0, 0, 0, 0, "R12");
        apply(0, 1, 0, 'h000000, 0, "R3");      // vector fetch from flash
        apply(0, 1, 0, 'h0000FF, 0, "R3");
        sweep("R2 before swap, R1 R6");
        apply(0, 1, 1, 'h018042, 0, "R4 other IO write");
        apply(0, 1, 0, 'h000004, 0, "R4 still flash");
        apply(0, 1, 0, 'h018040, 0, "R4 read of trigger");
        apply(0, 1, 0, 'h000000, 0, "R4 still flash");
        apply(0, 0, 1, 'h018040, 0, "R12 unstrobed trigger");
        apply(0, 1, 0, 'h000000, 0, "R12 flag held");
        apply(0, 1, 1, 'h018040, 0, "R4 trigger write");
        apply(0, 1, 0, 'h000000, 0, "R4 vector RAM");
        sweep("R2 after swap, R1 R6");
        apply(0, 1, 1, 'h018040, 0, "R5 second trigger");
        apply(0, 1, 0, 'h0000FF, 0, "R5 still RAM");
        for (int s = 0; s < 8; s++)              // R7 R10: every slot at an interior offset
            apply(0, 1, 0, 'h820000 + s * 16384 + 'h1235 + s, 0, "R7 R10 slot");
        for (int c = 0; c < 4; c++)              // R8 R11: each capability code
            apply(0, 1, 0, 'h95A5A5 + c, c, "R8 R11 dynamic");
        apply(0, 1, 0, 'h3FFFFE, 3, "R9 R11 no card");
        for (int k = 0; k < 16; k++) begin       // R12: idle cycles with arbitrary addresses
            lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
            apply(0, 0, k % 2, int'(lfsr), k % 4, "R12 idle");
        end
        apply(1, 1, 0, 'h000000, 0, "R5 reset cycle");
        apply(0, 1, 0, 'h000000, 0, "R5 flash after reset");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule